// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial peripheral interface master driven by software through a small 32-bit register window. Software picks a target by index and turns its select line on, sets clock polarity, clock phase, word size and clock divider, and then writes a word to the transmit register. That write launches one full-duplex exchange of 8 or 16 bits. When the last bit has been shifted, the received word is in the receive register and a completion flag is raised. Software clears that flag before it starts the next word.

The engine shifts the most significant bit first. It drives the serial clock, the serial data output and up to eight active-low select lines, and it samples the serial data input. A timing register can move the input sample point one system clock later than the clock edge. This gives margin for a slow target. A `busy` output shows that an exchange is in flight.

Top module: `spi_regmaster`

## Requirements
- R1: Registers are at these byte offsets: control 0x00, configuration 0x04, transmit 0x08, receive 0x0C (read only), completion flag 0x10, timing 0x18. Control, configuration and timing read back their written fields. Any other offset, including 0x20, reads zero.
- R2: Control bit 0 is the select enable and control bits [4:2] are the target index. `sel_n[i]` is low only when the enable is 1 and the index equals i. All other select lines stay high.
- R3: Configuration bit 11 sets the idle clock level (polarity) and bit 12 sets the phase. With phase 0, input is sampled and the target shifts on the first and second edge of each bit respectively. With phase 1 the roles of the two edges are swapped. All four combinations transfer data correctly in both directions.
- R4: After reset, `sclk` is low, every select line is high, `busy` is low and the timing register reads 0x40. Whenever no exchange is running, `sclk` rests at the configured polarity.
- R5: A write to the transmit register while idle starts one exchange. When `busy` falls, the receive register holds the received word and bit 0 of the completion flag reads 1.
- R6: Configuration bit 5 set selects 16-bit words, using transmit bits [15:0] and filling receive bits [15:0]. Clear selects 8-bit words, using transmit bits [7:0] and filling receive bits [7:0] with zeros above. Bits go out and come in most significant first.
- R7: A write to the transmit register while `busy` is high is ignored. The register keeps its value and the exchange in flight is unchanged.
- R8: Any write to the completion flag register clears it, whatever the data.
- R9: Each half period of `sclk` lasts (configuration bits [3:0] + 1) system clocks.
- R10: Timing bits [7:6] choose the input sample point. Value 2 samples `miso` one system clock after the sampling edge. Any other value samples on the edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_en |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| busy | output | 1 | An exchange is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |
| sel_n | output | 8 | Active-low target select lines |

## Verification
The in-line assertions check four properties on every cycle: at most one select line is low, the resting clock level matches the polarity setting, a transmit write during an exchange cannot reload the shifter, and the completion flag follows the end of each exchange and each clearing write. Only the bench scenarios can show the rest. These are the bit values carried in each of the four clock modes and both word sizes, the half-period length, and that the late sample point really captures a later input value. For the last one, a deliberately skewed target changes its output just after each sampling edge.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int OFS_CTRL  = 'h00;
   localparam int OFS_CFG   = 'h04;
   localparam int OFS_TXD   = 'h08;
   localparam int OFS_RXD   = 'h0C;
   localparam int OFS_DONE  = 'h10;
   localparam int OFS_TIME  = 'h18;

   localparam int BIT_SEL_EN = 0;
   localparam int BIT_WIDE   = 5;
   localparam int BIT_POL    = 11;
   localparam int BIT_PHA    = 12;
   localparam int LATE_CODE  = 2;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_RUN,
      ENG_TAIL,
      ENG_DONE
   } eng_state_t;
endpackage

// File: rtl/spim_regs.sv
module spim_regs #(
   parameter int ADDR_W = 8,
   parameter int MAXW   = 16,
   parameter int DIV_W  = 4,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic [MAXW-1:0]   rx_word_i,
   output logic              txd_wr_o,
   output logic              sel_en_o,
   output logic [IDX_W-1:0]  sel_idx_o,
   output logic              pol_o,
   output logic              pha_o,
   output logic              wide_o,
   output logic [DIV_W-1:0]  half_div_o,
   output logic              late_o
);
   import spim_pkg::*;

   logic              wr;
   logic              sel_en_q;
   logic [IDX_W-1:0]  sel_idx_q;
   logic              pol_q, pha_q, wide_q;
   logic [DIV_W-1:0]  div_q;
   logic [1:0]        samp_q;
   logic [31:0]       txd_q;
   logic [MAXW-1:0]   rxd_q;
   logic              done_q;

   assign wr = bus_en && bus_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_en_q  <= 1'b0;
         sel_idx_q <= '0;
         pol_q     <= 1'b0;
         pha_q     <= 1'b0;
         wide_q    <= 1'b0;
         div_q     <= '0;
         samp_q    <= 2'd1;
         txd_q     <= '0;
         rxd_q     <= '0;
         done_q    <= 1'b0;
      end else begin
         if (wr && bus_addr == ADDR_W'(OFS_CTRL)) begin
            sel_en_q  <= bus_wdata[BIT_SEL_EN];
            sel_idx_q <= bus_wdata[2 +: IDX_W];
         end
         if (wr && bus_addr == ADDR_W'(OFS_CFG)) begin
            pol_q  <= bus_wdata[BIT_POL];
            pha_q  <= bus_wdata[BIT_PHA];
            wide_q <= bus_wdata[BIT_WIDE];
            div_q  <= bus_wdata[DIV_W-1:0];
         end
         if (wr && bus_addr == ADDR_W'(OFS_TIME))
            samp_q <= bus_wdata[7:6];
         if (wr && bus_addr == ADDR_W'(OFS_TXD) && !busy_i)
            txd_q <= bus_wdata;
         if (done_i) begin
            rxd_q  <= rx_word_i;
            done_q <= 1'b1;
         end else if (wr && bus_addr == ADDR_W'(OFS_DONE)) begin
            done_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_CTRL): begin
            bus_rdata[BIT_SEL_EN]  = sel_en_q;
            bus_rdata[2 +: IDX_W]  = sel_idx_q;
         end
         ADDR_W'(OFS_CFG): begin
            bus_rdata[BIT_POL]     = pol_q;
            bus_rdata[BIT_PHA]     = pha_q;
            bus_rdata[BIT_WIDE]    = wide_q;
            bus_rdata[DIV_W-1:0]   = div_q;
         end
         ADDR_W'(OFS_TXD):  bus_rdata = txd_q;
         ADDR_W'(OFS_RXD):  bus_rdata[MAXW-1:0] = rxd_q;
         ADDR_W'(OFS_DONE): bus_rdata[0] = done_q;
         ADDR_W'(OFS_TIME): bus_rdata[7:6] = samp_q;
         default:           bus_rdata = '0;
      endcase
   end

   assign txd_wr_o   = wr && bus_addr == ADDR_W'(OFS_TXD);
   assign sel_en_o   = sel_en_q;
   assign sel_idx_o  = sel_idx_q;
   assign pol_o      = pol_q;
   assign pha_o      = pha_q;
   assign wide_o     = wide_q;
   assign half_div_o = div_q;
   assign late_o     = (samp_q == 2'(LATE_CODE));

   // R5: a finishing exchange always raises the flag
   assert_flag_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> done_q);
   // R8: a write to the flag register clears it unless an exchange ends then
   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFS_DONE) && !done_i) |=> !done_q);
endmodule

// File: rtl/spim_divider.sv
module spim_divider #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] half_div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == half_div_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || tick_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int MAXW = 16,
   parameter int MINW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [MAXW-1:0] word_i,
   input  logic            pol_i,
   input  logic            pha_i,
   input  logic            wide_i,
   input  logic            late_i,
   input  logic            tick_i,
   input  logic            miso_i,
   output logic            run_o,
   output logic            busy_o,
   output logic            done_o,
   output logic [MAXW-1:0] rx_word_o,
   output logic            sclk_o,
   output logic            mosi_o
);
   import spim_pkg::*;

   localparam int EC_W = $clog2(2 * MAXW);
   localparam logic [EC_W-1:0] LAST_WIDE   = EC_W'(2 * MAXW - 1);
   localparam logic [EC_W-1:0] LAST_NARROW = EC_W'(2 * MINW - 1);

   eng_state_t       state_q;
   logic             sclk_q;
   logic [MAXW-1:0]  tx_sh, rx_sh, load_word;
   logic [EC_W-1:0]  edge_q, last_edge;
   logic             pend_q, pha_q, wide_q, late_q;
   logic             samp_edge, shift_edge;

   generate
      if (MAXW > MINW) begin : g_pad
         assign load_word = wide_i ? word_i : {word_i[MINW-1:0], {(MAXW-MINW){1'b0}}};
      end else begin : g_flat
         assign load_word = word_i;
      end
   endgenerate

   assign last_edge  = wide_q ? LAST_WIDE : LAST_NARROW;
   assign samp_edge  = pha_q ? edge_q[0] : !edge_q[0];
   assign shift_edge = pha_q ? (!edge_q[0] && edge_q != '0) : edge_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         sclk_q  <= 1'b0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         edge_q  <= '0;
         pend_q  <= 1'b0;
         pha_q   <= 1'b0;
         wide_q  <= 1'b0;
         late_q  <= 1'b0;
      end else begin
         case (state_q)
            ENG_IDLE: begin
               sclk_q <= pol_i;
               if (start_i) begin
                  tx_sh   <= load_word;
                  rx_sh   <= '0;
                  edge_q  <= '0;
                  pend_q  <= 1'b0;
                  pha_q   <= pha_i;
                  wide_q  <= wide_i;
                  late_q  <= late_i;
                  state_q <= ENG_RUN;
               end
            end
            ENG_RUN: begin
               if (pend_q) begin
                  rx_sh  <= {rx_sh[MAXW-2:0], miso_i};
                  pend_q <= 1'b0;
               end
               if (tick_i) begin
                  sclk_q <= ~sclk_q;
                  if (samp_edge) begin
                     if (late_q) pend_q <= 1'b1;
                     else        rx_sh  <= {rx_sh[MAXW-2:0], miso_i};
                  end
                  if (shift_edge)
                     tx_sh <= {tx_sh[MAXW-2:0], 1'b0};
                  edge_q <= edge_q + 1'b1;
                  if (edge_q == last_edge)
                     state_q <= ENG_TAIL;
               end
            end
            ENG_TAIL: begin
               if (pend_q) begin
                  rx_sh  <= {rx_sh[MAXW-2:0], miso_i};
                  pend_q <= 1'b0;
               end
               state_q <= ENG_DONE;
            end
            default: begin
               sclk_q  <= pol_i;
               state_q <= ENG_IDLE;
            end
         endcase
      end
   end

   assign run_o     = (state_q == ENG_RUN);
   assign busy_o    = (state_q != ENG_IDLE);
   assign done_o    = (state_q == ENG_DONE);
   assign rx_word_o = rx_sh;
   assign sclk_o    = sclk_q;
   assign mosi_o    = tx_sh[MAXW-1];

   // R4: the clock rests at the polarity level between exchanges
   assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ENG_IDLE && $past(state_q) == ENG_IDLE && $stable(pol_i)) |-> sclk_q == pol_i);
   // R7: a transmit write mid-exchange leaves the shifter alone
   assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ENG_RUN && start_i && !tick_i) |=> $stable(tx_sh));
   // R5: busy drops right after the completion cycle
   assert_busy_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
endmodule

// File: rtl/spim_seldec.sv
module spim_seldec #(
   parameter int NCS   = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [NCS-1:0]   sel_n_o
);
   generate
      for (genvar i = 0; i < NCS; i++) begin : g_line
         assign sel_n_o[i] = ~(en_i && idx_i == IDX_W'(i));
      end
   endgenerate

   // R2: never more than one target selected
   assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sel_n_o));
   // R2: disabled control leaves every line high
   assert_all_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> (&sel_n_o));
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster #(
   parameter int ADDR_W = 8,
   parameter int NCS    = 8,
   parameter int MAXW   = 16,
   parameter int MINW   = 8,
   parameter int DIV_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NCS-1:0]    sel_n
);
   localparam int IDX_W = 3;

   initial begin
      assert (NCS >= 1 && NCS <= (1 << IDX_W)) else $error("NCS out of range");
      assert (MAXW == 2 * MINW && MAXW <= 16) else $error("word sizes unsupported");
      assert (DIV_W >= 1 && DIV_W <= 5) else $error("DIV_W out of range");
      assert (ADDR_W >= 5) else $error("ADDR_W too narrow");
   end

   logic              txd_wr, sel_en, pol, pha, wide, late;
   logic [IDX_W-1:0]  sel_idx;
   logic [DIV_W-1:0]  half_div;
   logic              run, done, tick;
   logic [MAXW-1:0]   rx_word;

   spim_regs #(.ADDR_W(ADDR_W), .MAXW(MAXW), .DIV_W(DIV_W), .IDX_W(IDX_W)) u_regs (
      .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .busy_i(busy), .done_i(done), .rx_word_i(rx_word),
      .txd_wr_o(txd_wr), .sel_en_o(sel_en), .sel_idx_o(sel_idx),
      .pol_o(pol), .pha_o(pha), .wide_o(wide), .half_div_o(half_div), .late_o(late)
   );

   spim_divider #(.DIV_W(DIV_W)) u_div (
      .clk, .rst_n, .run_i(run), .half_div_i(half_div), .tick_o(tick)
   );

   spim_shifter #(.MAXW(MAXW), .MINW(MINW)) u_shift (
      .clk, .rst_n, .start_i(txd_wr), .word_i(bus_wdata[MAXW-1:0]),
      .pol_i(pol), .pha_i(pha), .wide_i(wide), .late_i(late), .tick_i(tick),
      .miso_i(miso), .run_o(run), .busy_o(busy), .done_o(done),
      .rx_word_o(rx_word), .sclk_o(sclk), .mosi_o(mosi)
   );

   spim_seldec #(.NCS(NCS), .IDX_W(IDX_W)) u_sel (
      .clk, .rst_n, .en_i(sel_en), .idx_i(sel_idx), .sel_n_o(sel_n)
   );
endmodule

// File: tb/spi_regmaster_bench.sv
`timescale 1ns/1ps
module spi_regmaster_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        busy, sclk, mosi;
   logic        miso = 1'b0;
   logic [7:0]  sel_n;

   always #2 clk = ~clk;

   spi_regmaster u_spi_regmaster (
      .clk, .rst_n, .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .busy, .sclk, .mosi, .miso, .sel_n
   );

   int checks = 0, errors = 0;
   logic [31:0] exp_rxd_q[$];
   logic [31:0] exp_tgt_q[$];

   bit          slv_arm = 0, slv_pha = 0, slv_skew = 0, arm_seen = 0;
   int          slv_n = 8, slv_k = 0;
   logic [15:0] slv_word = '0, slv_rx = '0;
   longint      t_last = 0, t_prev = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_en = 1'b1; bus_we = 1'b1;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
      #1 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   // target model: shifts on launch edges, or with skew changes just after each sample edge
   always @(sclk or slv_arm) begin
      if (!slv_arm) arm_seen = 0;
      else if (!arm_seen) begin
         arm_seen = 1; slv_k = 0; slv_rx = '0;
         miso = slv_skew ? 1'b0 : slv_word[slv_n-1];
      end else begin
         t_prev = t_last; t_last = $time;
         if (slv_pha ? (slv_k % 2 == 1) : (slv_k % 2 == 0)) begin
            slv_rx = {slv_rx[14:0], mosi};
            if (slv_skew) miso <= #2 slv_word[slv_n-1-slv_k/2];
         end else if (!slv_skew) begin
            int idx;
            idx = slv_pha ? slv_k / 2 : (slv_k + 1) / 2;
            if (idx < slv_n) miso = slv_word[slv_n-1-idx];
         end
         slv_k++;
      end
   end

   // monitor: word seen by the target against the scoreboard
   bit prev_busy = 0;
   always @(negedge clk) begin
      if (prev_busy && !busy && exp_tgt_q.size() > 0) begin
         logic [31:0] e;
         logic [15:0] m;
         e = exp_tgt_q.pop_front();
         m = e[31:16];
         chk((slv_rx & m) == e[15:0], "R6 target received word", {16'b0, slv_rx & m}, {16'b0, e[15:0]});
      end
      prev_busy = busy;
   end

   task automatic xfer(input bit pol, input bit pha, input bit wide, input logic [3:0] div,
                       input bit late, input logic [15:0] tx, input logic [15:0] sw,
                       input bit skew, input bit poke, input string tag);
      logic [31:0] v, cfg, e;
      logic [15:0] m, exp_rx;
      m = wide ? 16'hFFFF : 16'h00FF;
      cfg = '0; cfg[12] = pha; cfg[11] = pol; cfg[5] = wide; cfg[3:0] = div;
      wr(8'h04, cfg);
      wr(8'h18, late ? 32'h80 : 32'h40);
      wr(8'h00, 32'h0000_000D);
      exp_rx = skew ? (late ? (sw & m) : ((sw & m) >> 1)) : (sw & m);
      exp_rxd_q.push_back({16'b0, exp_rx});
      exp_tgt_q.push_back({m, tx & m});
      slv_word = sw & m; slv_n = wide ? 16 : 8; slv_pha = pha; slv_skew = skew;
      @(negedge clk); slv_arm = 1;
      wr(8'h10, 32'h0);
      wr(8'h08, {16'hA0A0, tx});
      chk(sel_n == 8'hF7, {tag, " R2 select index 3 low"}, {24'b0, sel_n}, 32'hF7);
      if (poke) begin
         wr(8'h08, {16'h0, ~tx});
         rd(8'h08, v);
         chk(v == {16'hA0A0, tx}, "R7 transmit write while busy ignored", v, {16'hA0A0, tx});
      end
      while (busy) @(negedge clk);
      rd(8'h0C, v);
      e = exp_rxd_q.pop_front();
      chk(v == e, {tag, " R3 R5 R6 R10 received word"}, v, e);
      rd(8'h10, v);
      chk(v == 32'h1, {tag, " R5 completion flag"}, v, 32'h1);
      chk((t_last - t_prev) == longint'((div + 1) * 4), {tag, " R9 half period"},
          32'(t_last - t_prev), 32'((div + 1) * 4));
      chk(sclk == pol, {tag, " R4 idle clock level"}, {31'b0, sclk}, {31'b0, pol});
      slv_arm = 0;
   endtask

   initial begin
      #(200000 * 4);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sel_n == 8'hFF, "R4 reset selects high", {24'b0, sel_n}, 32'hFF);
      chk(busy == 1'b0, "R4 reset not busy", {31'b0, busy}, 32'h0);
      chk(sclk == 1'b0, "R4 reset clock low", {31'b0, sclk}, 32'h0);
      rd(8'h18, v);
      chk(v == 32'h40, "R4 timing default", v, 32'h40);

      wr(8'h04, 32'h0000_1823);
      rd(8'h04, v);
      chk(v == 32'h0000_1823, "R1 configuration readback", v, 32'h1823);
      wr(8'h04, 32'h0);
      wr(8'h00, 32'h0000_0015);
      rd(8'h00, v);
      chk(v == 32'h15, "R1 control readback", v, 32'h15);
      chk(sel_n == 8'hDF, "R2 index 5 selected", {24'b0, sel_n}, 32'hDF);
      wr(8'h00, 32'h0000_0014);
      chk(sel_n == 8'hFF, "R2 enable off", {24'b0, sel_n}, 32'hFF);
      wr(8'h00, 32'h0000_0001);
      chk(sel_n == 8'hFE, "R2 index 0 selected", {24'b0, sel_n}, 32'hFE);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h20, v);
      chk(v == 32'h0, "R1 unmapped offset reads zero", v, 32'h0);

      xfer(0, 0, 0, 4'd1, 0, 16'h00A5, 16'h003C, 0, 0, "mode0 8b");
      xfer(0, 1, 0, 4'd0, 0, 16'h005A, 16'h00C3, 0, 0, "mode1 8b");
      xfer(1, 0, 0, 4'd2, 0, 16'h0081, 16'h007E, 0, 0, "mode2 8b");
      xfer(1, 1, 1, 4'd1, 0, 16'hBEEF, 16'h1234, 0, 0, "mode3 16b");
      xfer(0, 0, 1, 4'd3, 0, 16'h8001, 16'hF00D, 0, 0, "mode0 16b");
      xfer(1, 1, 0, 4'd0, 1, 16'h0033, 16'h00E7, 0, 0, "mode3 late");
      xfer(0, 0, 0, 4'd2, 0, 16'h0099, 16'h00B5, 1, 0, "skew normal R10");
      xfer(0, 0, 0, 4'd2, 1, 16'h0066, 16'h00B5, 1, 0, "skew late R10");
      xfer(0, 1, 1, 4'd3, 0, 16'h1357, 16'h2468, 0, 1, "poke R7");

      wr(8'h10, 32'hDEAD_BEEF);
      rd(8'h10, v);
      chk(v == 32'h0, "R8 nonzero write clears flag", v, 32'h0);

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule